// File: doc/BRIEF.md
# Slot-Counted In-Order Retire Queue

This block keeps the program order of instructions in flight in an out-of-order core. A new instruction gets a token when it is dispatched. The execution side reports completion by quoting that token back. The block then retires finished instructions strictly in the order they were dispatched.

Every instruction reserves as many capacity slots as it has micro-ops, out of a budget of `CAP` slots. Tokens are positions in a ring of `2*CAP` positions. An instruction moves the tail pointer by its micro-op count, with a minimum step of one. An instruction with no micro-ops therefore still takes a ring position but uses no capacity. Retirement happens by itself, in the cycle in which the head entry and the entries after it are complete. The number of entries that may retire in one cycle is limited by a parameter.

Illegal requests leave the state unchanged. They are reported on a two-bit error output. Bit 0 marks a rejected dispatch and bit 1 marks a rejected completion.

Top module: `retire_queue`

## Requirements
- R1: After reset, the free count is `CAP`, the dispatch token and the head token are 0, nothing retires, and the error output is 0.
- R2: In the same cycle, `disp_tok_o` shows the token the next dispatch will get. This is the current tail position. An accepted dispatch moves the tail by max(1, k) positions.
- R3: An accepted dispatch lowers `free_o` by k at the next edge. A micro-op count above `CAP` is treated as `CAP`.
- R4: A dispatch with k = 0 takes one ring position but leaves the free count unchanged.
- R5: `disp_stall_o` is high when the clamped k exceeds the free count, or when the ring lacks max(1, k) unused positions. A dispatch attempted while stalled changes no state and sets error bit 0 in the next cycle.
- R6: An accepted completion sets the executed flag of the entry that starts at the given token. A completion of a position that holds no entry start, or of an entry already executed, changes no state and sets error bit 1 in the next cycle.
- R7: Only an executed entry at the head retires, and entries retire strictly in dispatch order. `ret_cnt_o` gives the number of entries retiring at the coming edge, and `ret_tok_o` gives the head token.
- R8: At most `MAX_RET` entries retire per cycle. When `MAX_RET` is 0, up to `2*CAP` entries retire per cycle.
- R9: A retiring entry returns its slot count to the free count at the edge. The head then advances by max(1, slot count).
- R10: All token and pointer arithmetic wraps modulo `2*CAP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_uops_i | input | UOP_W | Micro-op count of the dispatched instruction |
| disp_stall_o | output | 1 | Dispatch of `disp_uops_i` would be refused |
| disp_tok_o | output | $clog2(2*CAP) | Token the current dispatch receives |
| cmp_valid_i | input | 1 | Execute-complete event |
| cmp_tok_i | input | $clog2(2*CAP) | Token of the completed instruction |
| ret_cnt_o | output | $clog2(LANES+1) | Entries retiring at the coming edge |
| ret_tok_o | output | $clog2(2*CAP) | Token at the head of the queue |
| free_o | output | $clog2(CAP+1) | Free capacity slots |
| err_o | output | 2 | Bit 0: dispatch rejected; bit 1: completion rejected |

## Verification
Four outputs are combinational views of the registered state: the dispatch token, the stall flag, the retire count and the head token. They are due in the same cycle as the stimulus. The bench samples them a short delay after driving the inputs at the falling edge, before the next rising edge. The free count and the error code pass through one register, so they are due one cycle after the request. The bench samples them just after the rising edge that captures the request. Retirement that follows a completion is checked one cycle later, because the executed flag must be registered before the head can leave.

// File: rtl/rq_pkg.sv
package rq_pkg;

   localparam int ERR_W    = 2;
   localparam int ERR_DISP = 0;
   localparam int ERR_CMP  = 1;

   // Positions an entry occupies in the ring: zero-count entries still take one.
   function automatic int rq_step(input int cnt);
      return (cnt == 0) ? 1 : cnt;
   endfunction

   // Single-subtraction wrap; valid while pos < 2*ring.
   function automatic int rq_wrap(input int pos, input int ring);
      return (pos >= ring) ? pos - ring : pos;
   endfunction

endpackage

// File: rtl/rq_disp_ctl.sv
module rq_disp_ctl #(
   parameter int CAP   = 8,
   parameter int UOP_W = 4,
   parameter int RING  = 2 * CAP,
   parameter int TW    = $clog2(RING),
   parameter int CW    = $clog2(CAP + 1),
   parameter int PW    = $clog2(RING + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             disp_valid_i,
   input  logic [UOP_W-1:0] disp_uops_i,
   input  logic [CW-1:0]    free_i,
   input  logic [PW-1:0]    pos_used_i,
   output logic [TW-1:0]    tail_o,
   output logic [CW-1:0]    k_o,
   output logic [CW-1:0]    step_o,
   output logic             stall_o,
   output logic             fire_o
);
   import rq_pkg::*;

   localparam int UOP_MAX = (1 << UOP_W) - 1;

   logic [TW-1:0] tail_q;
   logic [CW-1:0] k_c;

   generate
      if (UOP_MAX > CAP) begin : g_clamp
         assign k_c = (int'(disp_uops_i) > CAP) ? CW'(CAP) : CW'(disp_uops_i);
      end else begin : g_pass
         assign k_c = CW'(disp_uops_i);
      end
   endgenerate

   assign k_o     = k_c;
   assign step_o  = CW'(rq_step(int'(k_c)));
   assign stall_o = (k_c > free_i) || ((int'(pos_used_i) + int'(step_o)) > RING);
   assign fire_o  = disp_valid_i && !stall_o;
   assign tail_o  = tail_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tail_q <= '0;
      end else if (fire_o) begin
         tail_q <= TW'(rq_wrap(int'(tail_q) + int'(step_o), RING));
      end
   end

   // R2
   tail_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fire_o |=> $stable(tail_q));

endmodule

// File: rtl/rq_entry_store.sv
module rq_entry_store #(
   parameter int RING = 16,
   parameter int TW   = $clog2(RING),
   parameter int CW   = 4
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_en_i,
   input  logic [TW-1:0]            wr_idx_i,
   input  logic [CW-1:0]            wr_slots_i,
   input  logic                     cmp_valid_i,
   input  logic [TW-1:0]            cmp_tok_i,
   input  logic [RING-1:0]          clr_i,
   output logic [RING-1:0]          valid_o,
   output logic [RING-1:0]          exec_o,
   output logic [RING-1:0][CW-1:0]  slots_o,
   output logic                     cmp_bad_o
);

   logic [RING-1:0]         valid_q;
   logic [RING-1:0]         exec_q;
   logic [RING-1:0][CW-1:0] slots_q;
   logic [RING-1:0]         wr_hit;
   logic [RING-1:0]         cmp_hit;
   logic                    tok_ok;

   assign tok_ok    = int'(cmp_tok_i) < RING;
   assign cmp_bad_o = cmp_valid_i &&
                      (!tok_ok || !valid_q[cmp_tok_i] || exec_q[cmp_tok_i]);

   generate
      for (genvar p = 0; p < RING; p++) begin : g_dec
         assign wr_hit[p]  = wr_en_i && (wr_idx_i == TW'(p));
         assign cmp_hit[p] = cmp_valid_i && !cmp_bad_o && (cmp_tok_i == TW'(p));
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= '0;
         exec_q  <= '0;
         slots_q <= '0;
      end else begin
         for (int p = 0; p < RING; p++) begin
            if (clr_i[p]) begin
               valid_q[p] <= 1'b0;
               exec_q[p]  <= 1'b0;
               slots_q[p] <= '0;
            end else if (wr_hit[p]) begin
               valid_q[p] <= 1'b1;
               exec_q[p]  <= 1'b0;
               slots_q[p] <= wr_slots_i;
            end else if (cmp_hit[p]) begin
               exec_q[p]  <= 1'b1;
            end
         end
      end
   end

   assign valid_o = valid_q;
   assign exec_o  = exec_q;
   assign slots_o = slots_q;

   // R6
   cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_valid_i && !cmp_bad_o) |=> exec_q[$past(cmp_tok_i)]);

   // R6
   cmp_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_valid_i && !wr_en_i && clr_i == '0 && cmp_bad_o) |=> $stable(exec_q));

endmodule

// File: rtl/rq_retire_sel.sv
module rq_retire_sel #(
   parameter int RING  = 16,
   parameter int LANES = 2,
   parameter int TW    = $clog2(RING),
   parameter int CW    = 4,
   parameter int PW    = $clog2(RING + 1),
   parameter int NW    = $clog2(LANES + 1)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [TW-1:0]           head_i,
   input  logic [RING-1:0]         valid_i,
   input  logic [RING-1:0]         exec_i,
   input  logic [RING-1:0][CW-1:0] slots_i,
   output logic [NW-1:0]           ret_num_o,
   output logic [CW-1:0]           freed_o,
   output logic [PW-1:0]           pos_freed_o,
   output logic [TW-1:0]           head_nxt_o,
   output logic [RING-1:0]         clr_o
);
   import rq_pkg::*;

   logic [LANES-1:0][TW-1:0] lane_idx;
   logic [LANES-1:0]         lane_ok;

   always_comb begin
      logic [TW-1:0] cur;
      logic          go;
      int            n;
      int            fr;
      int            pf;
      cur = head_i;
      go  = 1'b1;
      n   = 0;
      fr  = 0;
      pf  = 0;
      for (int l = 0; l < LANES; l++) begin
         lane_idx[l] = cur;
         lane_ok[l]  = go && valid_i[cur] && exec_i[cur];
         go          = lane_ok[l];
         if (lane_ok[l]) begin
            n   = n + 1;
            fr  = fr + int'(slots_i[cur]);
            pf  = pf + rq_step(int'(slots_i[cur]));
            cur = TW'(rq_wrap(int'(cur) + rq_step(int'(slots_i[cur])), RING));
         end
      end
      ret_num_o   = NW'(n);
      freed_o     = CW'(fr);
      pos_freed_o = PW'(pf);
      head_nxt_o  = cur;
   end

   generate
      for (genvar p = 0; p < RING; p++) begin : g_clr
         always_comb begin
            clr_o[p] = 1'b0;
            for (int l = 0; l < LANES; l++) begin
               if (lane_ok[l] && lane_idx[l] == TW'(p)) clr_o[p] = 1'b1;
            end
         end
      end
   endgenerate

   // R7
   head_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_num_o != '0) |-> (valid_i[head_i] && exec_i[head_i]));

   // R8
   ret_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(clr_o) == int'(ret_num_o));

endmodule

// File: rtl/retire_queue.sv
module retire_queue #(
   parameter int CAP     = 8,
   parameter int UOP_W   = 4,
   parameter int MAX_RET = 2,
   localparam int RING   = 2 * CAP,
   localparam int TW     = $clog2(RING),
   localparam int CW     = $clog2(CAP + 1),
   localparam int PW     = $clog2(RING + 1),
   localparam int LANES  = (MAX_RET == 0 || MAX_RET > RING) ? RING : MAX_RET,
   localparam int NW     = $clog2(LANES + 1)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    disp_valid_i,
   input  logic [UOP_W-1:0]        disp_uops_i,
   output logic                    disp_stall_o,
   output logic [TW-1:0]           disp_tok_o,
   input  logic                    cmp_valid_i,
   input  logic [TW-1:0]           cmp_tok_i,
   output logic [NW-1:0]           ret_cnt_o,
   output logic [TW-1:0]           ret_tok_o,
   output logic [CW-1:0]           free_o,
   output logic [rq_pkg::ERR_W-1:0] err_o
);
   import rq_pkg::*;

   generate
      if (CAP < 1) begin : g_bad_cap
         $error("retire_queue: CAP must be at least 1");
      end
      if (UOP_W < 1) begin : g_bad_uop
         $error("retire_queue: UOP_W must be at least 1");
      end
      if (MAX_RET < 0) begin : g_bad_ret
         $error("retire_queue: MAX_RET must not be negative");
      end
   endgenerate

   logic [CW-1:0]           free_q;
   logic [PW-1:0]           pos_used_q;
   logic [TW-1:0]           head_q;
   logic [ERR_W-1:0]        err_q;

   logic [TW-1:0]           tail;
   logic [CW-1:0]           disp_k;
   logic [CW-1:0]           disp_step;
   logic                    disp_fire;
   logic                    stall;

   logic [RING-1:0]         ent_valid;
   logic [RING-1:0]         ent_exec;
   logic [RING-1:0][CW-1:0] ent_slots;
   logic                    cmp_bad;

   logic [NW-1:0]           ret_num;
   logic [CW-1:0]           freed;
   logic [PW-1:0]           pos_freed;
   logic [TW-1:0]           head_nxt;
   logic [RING-1:0]         clr;

   rq_disp_ctl #(
      .CAP   (CAP),
      .UOP_W (UOP_W),
      .RING  (RING),
      .TW    (TW),
      .CW    (CW),
      .PW    (PW)
   ) disp_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .disp_valid_i (disp_valid_i),
      .disp_uops_i  (disp_uops_i),
      .free_i       (free_q),
      .pos_used_i   (pos_used_q),
      .tail_o       (tail),
      .k_o          (disp_k),
      .step_o       (disp_step),
      .stall_o      (stall),
      .fire_o       (disp_fire)
   );

   rq_entry_store #(
      .RING (RING),
      .TW   (TW),
      .CW   (CW)
   ) store_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (disp_fire),
      .wr_idx_i    (tail),
      .wr_slots_i  (disp_k),
      .cmp_valid_i (cmp_valid_i),
      .cmp_tok_i   (cmp_tok_i),
      .clr_i       (clr),
      .valid_o     (ent_valid),
      .exec_o      (ent_exec),
      .slots_o     (ent_slots),
      .cmp_bad_o   (cmp_bad)
   );

   rq_retire_sel #(
      .RING  (RING),
      .LANES (LANES),
      .TW    (TW),
      .CW    (CW),
      .PW    (PW),
      .NW    (NW)
   ) ret_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .head_i      (head_q),
      .valid_i     (ent_valid),
      .exec_i      (ent_exec),
      .slots_i     (ent_slots),
      .ret_num_o   (ret_num),
      .freed_o     (freed),
      .pos_freed_o (pos_freed),
      .head_nxt_o  (head_nxt),
      .clr_o       (clr)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         free_q     <= CW'(CAP);
         pos_used_q <= '0;
         head_q     <= '0;
         err_q      <= '0;
      end else begin
         free_q     <= free_q - (disp_fire ? disp_k : '0) + freed;
         pos_used_q <= pos_used_q + (disp_fire ? PW'(disp_step) : '0) - pos_freed;
         head_q     <= head_nxt;
         err_q[ERR_DISP] <= disp_valid_i && stall;
         err_q[ERR_CMP]  <= cmp_bad;
      end
   end

   assign disp_stall_o = stall;
   assign disp_tok_o   = tail;
   assign ret_cnt_o    = ret_num;
   assign ret_tok_o    = head_q;
   assign free_o       = free_q;
   assign err_o        = err_q;

   // R3
   free_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(free_q) <= CAP);

   // R5
   stall_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_valid_i && disp_stall_o) |=> err_o[ERR_DISP]);

   // R4
   zero_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_fire && disp_k == '0) |=> (free_q >= $past(free_q)));

   // R10
   pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(pos_used_q) <= RING);

endmodule

// File: tb/retire_queue_tb.sv
module retire_queue_tb_top;

   localparam int CAP   = 8;
   localparam int UOP_W = 4;
   localparam int MAXR  = 2;
   localparam int RING  = 2 * CAP;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       disp_valid_i = 1'b0;
   logic [3:0] disp_uops_i = '0;
   logic       disp_stall_o;
   logic [3:0] disp_tok_o;
   logic       cmp_valid_i = 1'b0;
   logic [3:0] cmp_tok_i = '0;
   logic [1:0] ret_cnt_o;
   logic [3:0] ret_tok_o;
   logic [3:0] free_o;
   logic [1:0] err_o;

   int compared = 0;
   int mismatched = 0;

   always #5 clk_i = ~clk_i;

   retire_queue #(.CAP(CAP), .UOP_W(UOP_W), .MAX_RET(MAXR)) dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .disp_valid_i (disp_valid_i),
      .disp_uops_i  (disp_uops_i),
      .disp_stall_o (disp_stall_o),
      .disp_tok_o   (disp_tok_o),
      .cmp_valid_i  (cmp_valid_i),
      .cmp_tok_i    (cmp_tok_i),
      .ret_cnt_o    (ret_cnt_o),
      .ret_tok_o    (ret_tok_o),
      .free_o       (free_o),
      .err_o        (err_o)
   );

   typedef struct packed {
      logic       dv;
      logic [3:0] du;
      logic       cv;
      logic [3:0] ct;
      logic [3:0] etok;
      logic       estall;
      logic [1:0] ercnt;
      logic [3:0] ertok;
      logic [3:0] efree;
      logic [1:0] eerr;
      logic [7:0] req;
   } vec_t;

   // dv du cv ct | tok stall rcnt rtok | free err | requirement
   localparam int NV = 26;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 4'd3,  1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 4'd0,  4'd5, 2'd0, 8'd3},  // R3
      '{1'b1, 4'd0,  1'b0, 4'd0,  4'd3,  1'b0, 2'd0, 4'd0,  4'd5, 2'd0, 8'd4},  // R4
      '{1'b1, 4'd2,  1'b0, 4'd0,  4'd4,  1'b0, 2'd0, 4'd0,  4'd3, 2'd0, 8'd2},  // R2
      '{1'b1, 4'd4,  1'b0, 4'd0,  4'd6,  1'b1, 2'd0, 4'd0,  4'd3, 2'd1, 8'd5},  // R5
      '{1'b0, 4'd0,  1'b1, 4'd3,  4'd6,  1'b0, 2'd0, 4'd0,  4'd3, 2'd0, 8'd6},  // R6
      '{1'b0, 4'd0,  1'b1, 4'd3,  4'd6,  1'b0, 2'd0, 4'd0,  4'd3, 2'd2, 8'd6},  // R6 double
      '{1'b0, 4'd0,  1'b1, 4'd0,  4'd6,  1'b0, 2'd0, 4'd0,  4'd3, 2'd0, 8'd7},  // R7
      '{1'b0, 4'd0,  1'b0, 4'd0,  4'd6,  1'b0, 2'd2, 4'd0,  4'd6, 2'd0, 8'd7},  // R7
      '{1'b0, 4'd0,  1'b1, 4'd0,  4'd6,  1'b0, 2'd0, 4'd4,  4'd6, 2'd2, 8'd6},  // R6 retired
      '{1'b0, 4'd0,  1'b1, 4'd4,  4'd6,  1'b0, 2'd0, 4'd4,  4'd6, 2'd0, 8'd6},
      '{1'b0, 4'd0,  1'b0, 4'd0,  4'd6,  1'b0, 2'd1, 4'd4,  4'd8, 2'd0, 8'd9},  // R9
      '{1'b1, 4'd15, 1'b0, 4'd0,  4'd6,  1'b0, 2'd0, 4'd6,  4'd0, 2'd0, 8'd3},  // R3 clamp
      '{1'b1, 4'd0,  1'b0, 4'd0,  4'd14, 1'b0, 2'd0, 4'd6,  4'd0, 2'd0, 8'd4},  // R4
      '{1'b1, 4'd1,  1'b0, 4'd0,  4'd15, 1'b1, 2'd0, 4'd6,  4'd0, 2'd1, 8'd5},
      '{1'b0, 4'd0,  1'b1, 4'd5,  4'd15, 1'b0, 2'd0, 4'd6,  4'd0, 2'd2, 8'd6},  // mid-entry
      '{1'b0, 4'd0,  1'b1, 4'd14, 4'd15, 1'b0, 2'd0, 4'd6,  4'd0, 2'd0, 8'd6},
      '{1'b0, 4'd0,  1'b1, 4'd6,  4'd15, 1'b0, 2'd0, 4'd6,  4'd0, 2'd0, 8'd6},
      '{1'b0, 4'd0,  1'b0, 4'd0,  4'd15, 1'b0, 2'd2, 4'd6,  4'd8, 2'd0, 8'd8},  // R8
      '{1'b1, 4'd0,  1'b0, 4'd0,  4'd15, 1'b0, 2'd0, 4'd15, 4'd8, 2'd0, 8'd10}, // R10
      '{1'b1, 4'd0,  1'b0, 4'd0,  4'd0,  1'b0, 2'd0, 4'd15, 4'd8, 2'd0, 8'd10},
      '{1'b1, 4'd1,  1'b0, 4'd0,  4'd1,  1'b0, 2'd0, 4'd15, 4'd7, 2'd0, 8'd10},
      '{1'b0, 4'd0,  1'b1, 4'd1,  4'd2,  1'b0, 2'd0, 4'd15, 4'd7, 2'd0, 8'd7},
      '{1'b0, 4'd0,  1'b1, 4'd0,  4'd2,  1'b0, 2'd0, 4'd15, 4'd7, 2'd0, 8'd7},
      '{1'b0, 4'd0,  1'b1, 4'd15, 4'd2,  1'b0, 2'd0, 4'd15, 4'd7, 2'd0, 8'd7},
      '{1'b0, 4'd0,  1'b0, 4'd0,  4'd2,  1'b0, 2'd2, 4'd15, 4'd7, 2'd0, 8'd8},
      '{1'b0, 4'd0,  1'b0, 4'd0,  4'd2,  1'b0, 2'd1, 4'd1,  4'd8, 2'd0, 8'd9}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic dv, input int du, input logic cv, input int ct);
      @(negedge clk_i);
      disp_valid_i = dv;
      disp_uops_i  = 4'(du);
      cmp_valid_i  = cv;
      cmp_tok_i    = 4'(ct);
      #2;
   endtask

   task automatic after_edge;
      @(posedge clk_i);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk_i);
      #1;
      // R1: reset state
      chk("R1", "free", int'(free_o), CAP);
      chk("R1", "token", int'(disp_tok_o), 0);
      chk("R1", "head", int'(ret_tok_o), 0);
      chk("R1", "retire", int'(ret_cnt_o), 0);
      chk("R1", "err", int'(err_o), 0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      for (int v = 0; v < NV; v++) begin
         string rq;
         rq = $sformatf("R%0d", int'(TBL[v].req));
         drive(TBL[v].dv, int'(TBL[v].du), TBL[v].cv, int'(TBL[v].ct));
         chk(rq, "token", int'(disp_tok_o), int'(TBL[v].etok));
         chk(rq, "stall", int'(disp_stall_o), int'(TBL[v].estall));
         chk(rq, "ret_cnt", int'(ret_cnt_o), int'(TBL[v].ercnt));
         if (TBL[v].ercnt != 0) chk(rq, "ret_tok", int'(ret_tok_o), int'(TBL[v].ertok));
         after_edge();
         chk(rq, "free", int'(free_o), int'(TBL[v].efree));
         chk(rq, "err", int'(err_o), int'(TBL[v].eerr));
      end

      // R4 R10: fill every ring position with zero-count entries
      for (int i = 0; i < RING; i++) begin
         drive(1'b1, 0, 1'b0, 0);
         chk("R10", "fill token", int'(disp_tok_o), (2 + i) % RING);
         chk("R4", "fill stall", int'(disp_stall_o), 0);
         after_edge();
         chk("R4", "fill free", int'(free_o), CAP);
      end
      // R5: no position left although capacity is free
      drive(1'b1, 0, 1'b0, 0);
      chk("R5", "ring full stall", int'(disp_stall_o), 1);
      after_edge();
      chk("R5", "ring full err", int'(err_o), 1);
      // R7: complete in reverse, nothing may leave before the head
      for (int i = RING - 1; i >= 0; i--) begin
         drive(1'b0, 0, 1'b1, (2 + i) % RING);
         chk("R7", "reverse hold", int'(ret_cnt_o), 0);
         after_edge();
      end
      // R8: limit of two per cycle
      for (int j = 0; j < RING / MAXR; j++) begin
         drive(1'b0, 0, 1'b0, 0);
         chk("R8", "limit count", int'(ret_cnt_o), MAXR);
         chk("R7", "drain head", int'(ret_tok_o), (2 + MAXR * j) % RING);
         after_edge();
      end
      drive(1'b0, 0, 1'b0, 0);
      chk("R9", "drained", int'(ret_cnt_o), 0);
      chk("R9", "drained free", int'(free_o), CAP);

      // R1: reset mid-run
      drive(1'b1, 5, 1'b0, 0);
      after_edge();
      chk("R3", "before reset", int'(free_o), CAP - 5);
      disp_valid_i = 1'b0;
      rst_ni = 1'b0;
      #2;
      chk("R1", "reset free", int'(free_o), CAP);
      chk("R1", "reset token", int'(disp_tok_o), 0);
      chk("R1", "reset err", int'(err_o), 0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule